// File: doc/BRIEF.md
# I2C Slave Controller with Status-Code Handshake

This block is the slave side of a two-wire (I2C) bus interface. It brings the bus clock and data lines into the core clock domain and oversamples them there. It finds START and STOP conditions and shifts in the address byte. It answers when the address matches the programmed own address. It can also answer the general-call address 0x00, if the host has enabled that. The read/write bit of the address byte picks the mode: slave-receive for a write, slave-transmit for a read.

Each address, data and STOP event ends in the same handshake. The block raises a flag and presents an 8-bit status code. It holds the bus clock low until the host writes a clear pulse. The host answers the code, loads the next transmit byte or reads the received byte, and then clears the flag. An acknowledge-enable input serves three purposes. It marks an outgoing byte as the final one. It refuses an incoming byte. It detaches the slave from its own address altogether.

Bus pins are open-drain. The block only reports when it wants to pull a line low, and the surrounding pad logic forms the wired-AND.

Top module: `i2c_slv_stat`

## Requirements
- R1: The address input carries the 7-bit own address in bits 7:1. When an address byte with write bit 0 matches it and acknowledge-enable is 1, the slave pulls SDA low during the ninth clock, sets the flag and reports status 0x60.
- R2: A matching address byte with read bit 1 is acknowledged, sets the flag and reports status 0xA8. The slave then enters transmit mode.
- R3: With bit 0 of the address input set, address 0x00 with write is acknowledged with status 0x70, and each data byte acknowledged after it reports 0x90. With bit 0 clear, address 0x00 gets no acknowledge and no flag.
- R4: In receive mode with acknowledge-enable 1, a data byte is acknowledged, shown on the receive output and reported as 0x80. With acknowledge-enable 0, the byte is not acknowledged and is reported as 0x88, and the slave is no longer addressed, so later bytes get no acknowledge and no flag.
- R5: In transmit mode, the host's clear pulse loads the transmit input. That byte goes out MSB first, and SDA changes only while SCL is low. An ACK from the master on a byte that is not the last one reports 0xB8.
- R6: If acknowledge-enable is 0 when a transmit byte is loaded, that byte is the last one. It ends with 0xC0 when the master sends NACK, or 0xC8 when the master sends ACK. The slave then leaves SDA released, so further reads return 0xFF with no flag.
- R7: A NACK from the master on a byte that is not the last one reports 0xC0 and leaves the slave not addressed.
- R8: While acknowledge-enable is 0, the own address is not acknowledged and no flag is raised. Recognition resumes as soon as acknowledge-enable returns to 1.
- R9: While the flag is set, the slave drives SCL low, and the status is never the idle code 0xF8. SCL is released in the cycle after the clock edge that samples the clear pulse, and the status then reads 0xF8.
- R10: A STOP, or a repeated START, while the slave is addressed in receive or transmit mode sets the flag with status 0xA0 and returns the slave to the not-addressed state.
- R11: When the enable input is 0, or either the start or the stop request input is 1, the slave drives neither line, raises no flag and reads status 0xF8.
- R12: After reset the flag is clear, the status reads 0xF8 and both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Slave enable |
| ack_en_i | input | 1 | Acknowledge-enable control |
| sta_req_i | input | 1 | Start request; must be 0 for slave operation |
| sto_req_i | input | 1 | Stop request; must be 0 for slave operation |
| own_addr_i | input | DATA_W | Own address in bits 7:1, general-call enable in bit 0 |
| tx_data_i | input | DATA_W | Byte to transmit, taken on the clear pulse |
| flag_clr_i | input | 1 | Write-one pulse that clears the flag |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| irq_o | output | 1 | Event flag |
| status_o | output | 8 | Status code |
| rx_data_o | output | DATA_W | Last received byte |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with its default parameters: 8-bit data and a 2-stage synchroniser. With these, every address pattern and data byte is a plain byte, and the status codes are exactly the listed values. The bus clock phase in the bench lasts 20 core cycles. That is well above the roughly four cycles the slave needs to see an edge and respond. The directed bus sequences can therefore reach every mode change: last byte with ACK and with NACK, refused data, general call on and off, detach and re-attach, and STOP while addressed.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_TX
    } slv_st_e;

    localparam logic [7:0] SC_OWN_W     = 8'h60;
    localparam logic [7:0] SC_GC_W      = 8'h70;
    localparam logic [7:0] SC_RX_ACK    = 8'h80;
    localparam logic [7:0] SC_RX_NACK   = 8'h88;
    localparam logic [7:0] SC_GC_ACK    = 8'h90;
    localparam logic [7:0] SC_GC_NACK   = 8'h98;
    localparam logic [7:0] SC_STOP      = 8'hA0;
    localparam logic [7:0] SC_OWN_R     = 8'hA8;
    localparam logic [7:0] SC_TX_ACK    = 8'hB8;
    localparam logic [7:0] SC_TX_NACK   = 8'hC0;
    localparam logic [7:0] SC_LAST_ACK  = 8'hC8;
    localparam logic [7:0] SC_IDLE      = 8'hF8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.scl_sh = {r_q.scl_sh[STAGES-2:0], scl_i};
        r_d.sda_sh = {r_q.sda_sh[STAGES-2:0], sda_i};
        r_d.scl_p  = r_q.scl_sh[STAGES-1];
        r_d.sda_p  = r_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    assign scl_s     = r_q.scl_sh[STAGES-1];
    assign sda_s     = r_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~r_q.scl_p;
    assign scl_fall  = ~scl_s & r_q.scl_p;
    assign start_det = scl_s & r_q.scl_p & r_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & r_q.scl_p & ~r_q.sda_p & sda_s;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] cand,
    input  logic              ack_en,
    output logic              hit,
    output logic              is_gc
);
    logic own_m;
    logic gc_ok;

    always_comb begin
        own_m = (cand[DATA_W-1:1] == own_addr[DATA_W-1:1]);
        is_gc = (cand[DATA_W-1:1] == '0);
        gc_ok = is_gc & own_addr[0] & ~cand[0];
        hit   = ack_en & (own_m | gc_ok);
    end
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              flag_clr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              hit,
    input  logic              is_gc,
    output logic [DATA_W-1:0] cand,
    output logic              flag,
    output logic [7:0]        status,
    output logic [DATA_W-1:0] rx_data,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);

    typedef struct packed {
        slv_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] rxd;
        logic [7:0]        status;
        logic              flag;
        logic              sda_oe;
        logic              rw;
        logic              gc;
        logic              last;
        logic              acked;
    } core_t;

    localparam core_t RST = '{
        st: ST_IDLE, cnt: '0, sr: '0, rxd: '0, status: SC_IDLE,
        flag: 1'b0, sda_oe: 1'b0, rw: 1'b0, gc: 1'b0, last: 1'b0, acked: 1'b0
    };

    core_t r_q, r_d;
    logic  addressed;

    assign cand      = {r_q.sr[DATA_W-2:0], sda_s};
    assign addressed = (r_q.st == ST_RX) || (r_q.st == ST_TX);

    always_comb begin
        r_d = r_q;
        if (!active) begin
            r_d = RST;
        end else begin
            if (r_q.flag && flag_clr) begin
                r_d.flag   = 1'b0;
                r_d.status = SC_IDLE;
                if (r_q.st == ST_TX) begin
                    r_d.sr     = tx_data;
                    r_d.last   = ~ack_en;
                    r_d.sda_oe = ~tx_data[DATA_W-1];
                    r_d.cnt    = '0;
                end
            end
            if (start_det) begin
                if (addressed) begin
                    r_d.flag   = 1'b1;
                    r_d.status = SC_STOP;
                end
                r_d.st     = ST_ADDR;
                r_d.cnt    = '0;
                r_d.sda_oe = 1'b0;
            end else if (stop_det) begin
                if (addressed) begin
                    r_d.flag   = 1'b1;
                    r_d.status = SC_STOP;
                end
                r_d.st     = ST_IDLE;
                r_d.sda_oe = 1'b0;
            end else if (scl_rise) begin
                case (r_q.st)
                    ST_ADDR, ST_RX: begin
                        if (r_q.cnt < CNT_LAST) begin
                            r_d.sr  = cand;
                            r_d.cnt = r_q.cnt + 1'b1;
                            if (r_q.st == ST_ADDR && r_q.cnt == CNT_LAST - 1'b1) begin
                                r_d.rw = cand[0];
                                r_d.gc = is_gc;
                                if (!hit) r_d.st = ST_IDLE;
                            end
                        end else if (r_q.cnt == CNT_LAST) begin
                            r_d.cnt = CNT_ACK;
                        end
                    end
                    ST_TX: begin
                        if (r_q.cnt < CNT_LAST) begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end else if (r_q.cnt == CNT_LAST) begin
                            r_d.acked = ~sda_s;
                            r_d.cnt   = CNT_ACK;
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (r_q.st)
                    ST_ADDR: begin
                        if (r_q.cnt == CNT_LAST) begin
                            r_d.sda_oe = 1'b1;
                        end else if (r_q.cnt == CNT_ACK) begin
                            r_d.sda_oe = 1'b0;
                            r_d.flag   = 1'b1;
                            r_d.cnt    = '0;
                            if (r_q.rw) begin
                                r_d.st     = ST_TX;
                                r_d.status = SC_OWN_R;
                            end else begin
                                r_d.st     = ST_RX;
                                r_d.status = r_q.gc ? SC_GC_W : SC_OWN_W;
                            end
                        end
                    end
                    ST_RX: begin
                        if (r_q.cnt == CNT_LAST) begin
                            r_d.sda_oe = ack_en;
                            r_d.acked  = ack_en;
                        end else if (r_q.cnt == CNT_ACK) begin
                            r_d.sda_oe = 1'b0;
                            r_d.flag   = 1'b1;
                            r_d.cnt    = '0;
                            r_d.rxd    = r_q.sr;
                            if (r_q.acked) begin
                                r_d.status = r_q.gc ? SC_GC_ACK : SC_RX_ACK;
                            end else begin
                                r_d.status = r_q.gc ? SC_GC_NACK : SC_RX_NACK;
                                r_d.st     = ST_IDLE;
                            end
                        end
                    end
                    ST_TX: begin
                        if (r_q.cnt != '0 && r_q.cnt < CNT_LAST) begin
                            r_d.sr     = r_q.sr << 1;
                            r_d.sda_oe = ~r_q.sr[DATA_W-2];
                        end else if (r_q.cnt == CNT_LAST) begin
                            r_d.sda_oe = 1'b0;
                        end else if (r_q.cnt == CNT_ACK) begin
                            r_d.flag = 1'b1;
                            r_d.cnt  = '0;
                            if (r_q.last) begin
                                r_d.status = r_q.acked ? SC_LAST_ACK : SC_TX_NACK;
                                r_d.st     = ST_IDLE;
                            end else if (r_q.acked) begin
                                r_d.status = SC_TX_ACK;
                            end else begin
                                r_d.status = SC_TX_NACK;
                                r_d.st     = ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign flag    = r_q.flag;
    assign status  = r_q.status;
    assign rx_data = r_q.rxd;
    assign sda_oe  = r_q.sda_oe;

    // R5: our data line only moves while the bus clock is low
    p_sda_edge_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && r_q.sda_oe != $past(r_q.sda_oe)) |-> !scl_s);

    // R6: not addressed means the data line is released
    p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !r_q.sda_oe);

    // R9: a raised flag always carries a meaningful status
    p_status_on_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.flag |-> (r_q.status != SC_IDLE));

    // R9: byte events raise the flag only while the clock is low
    p_flag_rise_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.flag) && r_q.status != SC_STOP) |-> !scl_s);

    // R11: inactive slave stays quiet
    p_quiet_inactive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!r_q.flag && !r_q.sda_oe));

    // R1: receive-side acknowledge only in the ninth bit slot
    p_ack_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sda_oe && r_q.st != ST_TX) |-> (r_q.cnt >= CNT_LAST));
endmodule

// File: rtl/i2c_slv_stat.sv
module i2c_slv_stat #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ack_en_i,
    input  logic              sta_req_i,
    input  logic              sto_req_i,
    input  logic [DATA_W-1:0] own_addr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              flag_clr_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              irq_o,
    output logic [7:0]        status_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o
);
    logic              active;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              hit, is_gc, flag;
    logic [DATA_W-1:0] cand;

    assign active = en_i & ~sta_req_i & ~sto_req_i;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_addr_match #(.DATA_W(DATA_W)) u_match (
        .own_addr(own_addr_i), .cand(cand), .ack_en(ack_en_i),
        .hit(hit), .is_gc(is_gc)
    );

    i2c_slv_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .ack_en(ack_en_i),
        .tx_data(tx_data_i), .flag_clr(flag_clr_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .hit(hit), .is_gc(is_gc),
        .cand(cand), .flag(flag), .status(status_o), .rx_data(rx_data_o),
        .sda_oe(sda_oe_o)
    );

    assign irq_o    = flag;
    assign scl_oe_o = flag;

    // R12: lines released and idle status right after reset
    p_reset_state_r12: assert property (@(posedge clk)
        !rst_n |=> (!scl_oe_o && !sda_oe_o && status_o == 8'hF8) || !rst_n);
endmodule

// File: tb/i2c_slv_stat_test.sv
module i2c_slv_stat_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 20;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, en, ack_en, sta_req, sto_req, flag_clr;
    logic [7:0] own_addr, tx_data, status, rx_data;
    logic irq, scl_oe, sda_oe, scl_m, sda_m, scl_line, sda_line;
    int n_chk = 0, n_fail = 0;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_slv_stat uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .ack_en_i(ack_en),
        .sta_req_i(sta_req), .sto_req_i(sto_req), .own_addr_i(own_addr),
        .tx_data_i(tx_data), .flag_clr_i(flag_clr), .scl_i(scl_line), .sda_i(sda_line),
        .irq_o(irq), .status_o(status), .rx_data_o(rx_data),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_high(); wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b1; wait_high(); wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b; wt(HALF);
        scl_m = 1'b1; wait_high(); wt(HALF/2);
        r = sda_line; wt(HALF/2);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(~ack, r);
    endtask

    task automatic host_clr();
        flag_clr = 1'b1; wt(1); flag_clr = 1'b0;
    endtask

    // R9: stretch held, released one cycle after the clear pulse, status idle
    task automatic clr_checked(input string req);
        chk({req, " R9 scl held"}, int'(scl_oe & ~scl_line), 1);
        host_clr();
        chk({req, " R9 scl released"}, int'(scl_oe), 0);
        chk({req, " R9 status idle"}, int'(status), 8'hF8);
    endtask

    task automatic t_reset();
        chk("R12 irq", int'(irq), 0);
        chk("R12 status", int'(status), 8'hF8);
        chk("R12 lines", int'({scl_oe, sda_oe}), 0);
    endtask

    task automatic t_receive();
        logic a;
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        chk("R1 addr ack", int'(a), 1);
        chk("R1 irq", int'(irq), 1);
        chk("R1 status", int'(status), 8'h60);
        clr_checked("R1");
        m_wbyte(8'h5C, a);
        chk("R4 data ack", int'(a), 1);
        chk("R4 status", int'(status), 8'h80);
        chk("R4 rx", int'(rx_data), 8'h5C);
        host_clr();
        ack_en = 1'b0;
        m_wbyte(8'h33, a);
        chk("R4 refused nack", int'(a), 0);
        chk("R4 status 88", int'(status), 8'h88);
        chk("R4 rx 33", int'(rx_data), 8'h33);
        host_clr();
        ack_en = 1'b1;
        m_wbyte(8'h11, a);
        chk("R4 detached nack", int'(a), 0);
        chk("R4 detached irq", int'(irq), 0);
        m_stop();
        chk("R4 no A0 after detach", int'(irq), 0);
    endtask

    task automatic t_stop();
        logic a;
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        host_clr();
        m_wbyte(8'hE1, a);
        host_clr();
        m_stop();
        chk("R10 irq", int'(irq), 1);
        chk("R10 status", int'(status), 8'hA0);
        host_clr();
        m_start();
        m_wbyte(8'h7E, a);
        chk("R10 not addressed", int'(a), 0);
        m_stop();
    endtask

    task automatic t_gcall();
        logic a;
        own_addr = {OWN, 1'b1};
        m_start();
        m_wbyte(8'h00, a);
        chk("R3 gc ack", int'(a), 1);
        chk("R3 gc status", int'(status), 8'h70);
        host_clr();
        m_wbyte(8'hC3, a);
        chk("R3 gc data ack", int'(a), 1);
        chk("R3 gc data status", int'(status), 8'h90);
        host_clr();
        m_stop();
        host_clr();
        own_addr = {OWN, 1'b0};
        m_start();
        m_wbyte(8'h00, a);
        chk("R3 gc off nack", int'(a), 0);
        chk("R3 gc off irq", int'(irq), 0);
        m_stop();
    endtask

    task automatic t_transmit();
        logic a;
        logic [7:0] d;
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        chk("R2 addr ack", int'(a), 1);
        chk("R2 status", int'(status), 8'hA8);
        tx_data = 8'hA5;
        clr_checked("R2");
        m_rbyte(d, 1'b1);
        chk("R5 byte msb first", int'(d), 8'hA5);
        chk("R5 status", int'(status), 8'hB8);
        tx_data = 8'h3C;
        host_clr();
        m_rbyte(d, 1'b0);
        chk("R7 byte", int'(d), 8'h3C);
        chk("R7 status", int'(status), 8'hC0);
        host_clr();
        m_stop();
        chk("R7 not addressed", int'(irq), 0);
    endtask

    task automatic t_last();
        logic a;
        logic [7:0] d;
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        tx_data = 8'h96; ack_en = 1'b0;
        host_clr();
        m_rbyte(d, 1'b1);
        chk("R6 last byte", int'(d), 8'h96);
        chk("R6 status C8", int'(status), 8'hC8);
        host_clr();
        m_rbyte(d, 1'b1);
        chk("R6 reads ones", int'(d), 8'hFF);
        chk("R6 no irq", int'(irq), 0);
        m_stop();
        ack_en = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        tx_data = 8'h4B; ack_en = 1'b0;
        host_clr();
        m_rbyte(d, 1'b0);
        chk("R6 last byte nack", int'(d), 8'h4B);
        chk("R6 status C0", int'(status), 8'hC0);
        host_clr();
        m_stop();
        ack_en = 1'b1;
    endtask

    task automatic t_detach();
        logic a;
        ack_en = 1'b0;
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        chk("R8 no ack", int'(a), 0);
        chk("R8 no irq", int'(irq), 0);
        m_stop();
        ack_en = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        chk("R8 resumed ack", int'(a), 1);
        chk("R8 resumed status", int'(status), 8'h60);
        host_clr();
        m_stop();
        host_clr();
    endtask

    task automatic t_inactive();
        logic a;
        en = 1'b0;
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        chk("R11 disabled nack", int'(a), 0);
        chk("R11 disabled irq", int'(irq), 0);
        chk("R11 disabled status", int'(status), 8'hF8);
        m_stop();
        en = 1'b1; sta_req = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        chk("R11 start req nack", int'(a), 0);
        chk("R11 start req irq", int'(irq), 0);
        m_stop();
        sta_req = 1'b0; sto_req = 1'b1;
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        chk("R11 stop req nack", int'(a), 0);
        m_stop();
        sto_req = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b1; ack_en = 1'b1; sta_req = 1'b0; sto_req = 1'b0;
        flag_clr = 1'b0; own_addr = {OWN, 1'b0}; tx_data = 8'h00;
        scl_m = 1'b1; sda_m = 1'b1;
        wt(5);
        rst_n = 1'b1;
        wt(2);
        t_reset();
        t_receive();
        t_stop();
        t_gcall();
        t_transmit();
        t_last();
        t_detach();
        t_inactive();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule